// File: doc/BRIEF.md
# Range Cache Maintenance Sequencer

This block accepts one software cache-maintenance command and expands it into a stream of single-line requests for a data cache. A command names an operation (clean, invalidate or flush), a byte start address, a byte length, and whether it targets the whole cache. In range mode the sequencer works out every cache line that any byte of the range touches, with no alignment required of software. It then issues those lines one at a time, lowest address first. In whole-cache mode it issues every set/way index instead.

Requests leave over a valid/ready handshake and are held until the cache takes them. On the cycle after the final request is taken, a single-cycle completion pulse reports the outcome. Some commands cannot be carried out: a reserved operation code, or a range that runs past the top of the address space. For these, no request is issued and the completion pulse carries an error flag. Software then issues its own ordering fence. The cache side skips any line it does not hold, whatever the memory attributes of that line.

Top module: `cache_maint_seq`

## Requirements
- R1: `reqOp` carries the command's operation code unchanged: 0 = clean (write back dirty data and keep the line), 1 = invalidate (discard without write back), 2 = flush (write back, then discard). Code 3 is reserved. It produces no line request and completes with `error` high.
- R2: In range mode (`cmdAll` = 0), the first request carries `cmdStart` rounded down to a line boundary: the low log2(LINE_BYTES) bits are cleared, and LINE_BYTES is 64 by default.
- R3: In range mode, the last request carries the line that contains byte `cmdStart + cmdLen - 1`, and the number of requests is (last line - first line + 1).
- R4: Range requests rise by exactly one line (LINE_BYTES) from one request to the next. No line is skipped or repeated.
- R5: A `cmdLen` of zero produces exactly one request, the line that holds `cmdStart`.
- R6: If `cmdStart + cmdLen - 1` exceeds 2^ADDR_W - 1, the range wraps. No request is issued, and `done` pulses with `error` high. A range whose last byte is exactly the top address is legal.
- R7: In whole-cache mode, `reqAll` is high and `reqAddr` carries the indices 0 to NUM_SETS*NUM_WAYS-1 in ascending order, zero-extended in the low bits. `cmdStart` and `cmdLen` are ignored.
- R8: While `reqValid` is high and `reqReady` is low, `reqValid`, `reqAddr`, `reqOp` and `reqAll` stay unchanged on the next cycle.
- R9: `cmdReady` is high only while the block is idle. A command offered while the block is not idle is not taken, and it does not alter the request stream in progress.
- R10: `busy` is high from the cycle after acceptance until the last request is taken. `done` is high for exactly one cycle, the cycle after that. `error` is high only together with `done`, and `busy` and `done` are never high together.
- R11: After reset, `cmdReady` is 1 and `busy`, `done`, `error` and `reqValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command can be taken (idle) |
| cmdOp | input | 2 | Operation code |
| cmdAll | input | 1 | 1 = whole cache, 0 = byte range |
| cmdStart | input | ADDR_W | Byte start address |
| cmdLen | input | ADDR_W | Byte length |
| reqValid | output | 1 | Line request valid |
| reqReady | input | 1 | Cache accepts the line request |
| reqOp | output | 2 | Operation code for the line |
| reqAll | output | 1 | reqAddr is a set/way index |
| reqAddr | output | ADDR_W | Line-aligned address or set/way index |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Command rejected, valid with done |

## Verification
Two things can meet in the same cycle. One is a line request stalled by a low `reqReady`. The other is a fresh command presented on the command port while the sequencer is still walking a range. The bench keeps `cmdValid` high with unrelated fields for the whole of some walks while it withholds `reqReady` at random. It then checks three things. Each request must still match the line computed from the original command. The address must not move while a request is stalled. `cmdReady` must stay low until the completion pulse has passed.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [1:0] {
    OP_CLEAN = 2'd0,
    OP_INVAL = 2'd1,
    OP_FLUSH = 2'd2,
    OP_RSVD  = 2'd3
  } cmOp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIN   = 2'd2
  } seqState_e;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

endpackage

// File: rtl/cms_range_calc.sv
module cms_range_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SETS   = 64,
  parameter int NUM_WAYS   = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] len,
  input  logic              wholeCache,
  input  logic [1:0]        op,
  output logic [LINE_W-1:0] firstLine,
  output logic [LINE_W-1:0] lastLine,
  output logic              badCmd
);
  import cms_pkg::*;

  localparam int TOTAL = NUM_SETS * NUM_WAYS;

  logic [ADDR_W:0] lastByte;
  logic            wraps;

  // Inclusive last byte; the extra bit catches a range that runs off the top.
  always_comb begin
    if (len == '0) begin
      lastByte = {1'b0, start};
    end else begin
      lastByte = {1'b0, start} + {1'b0, len} - {{ADDR_W{1'b0}}, 1'b1};
    end
    wraps = lastByte[ADDR_W];
  end

  always_comb begin
    if (wholeCache) begin
      firstLine = '0;
      lastLine  = LINE_W'(TOTAL - 1);
    end else begin
      firstLine = start[ADDR_W-1:OFF_W];
      lastLine  = lastByte[ADDR_W-1:OFF_W];
    end
    badCmd = (op == OP_RSVD) || (!wholeCache && wraps);
  end

endmodule

// File: rtl/cms_datapath.sv
module cms_datapath #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SETS   = 64,
  parameter int NUM_WAYS   = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cms_pkg::seqStrobe_t strobe,
  input  logic [1:0]          cmdOp,
  input  logic                cmdAll,
  input  logic [ADDR_W-1:0]   cmdStart,
  input  logic [ADDR_W-1:0]   cmdLen,
  output logic                cmdBad,
  output logic                lastHit,
  output logic                errFlag,
  output logic [1:0]          reqOp,
  output logic                reqAll,
  output logic [ADDR_W-1:0]   reqAddr
);

  logic [LINE_W-1:0] firstLineIn;
  logic [LINE_W-1:0] lastLineIn;
  logic [LINE_W-1:0] curLine;
  logic [LINE_W-1:0] endLine;
  logic [1:0]        opReg;
  logic              allReg;
  logic              errReg;

  cms_range_calc #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_SETS  (NUM_SETS),
    .NUM_WAYS  (NUM_WAYS)
  ) u_calc (
    .start     (cmdStart),
    .len       (cmdLen),
    .wholeCache(cmdAll),
    .op        (cmdOp),
    .firstLine (firstLineIn),
    .lastLine  (lastLineIn),
    .badCmd    (cmdBad)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLine <= '0;
      endLine <= '0;
      opReg   <= '0;
      allReg  <= 1'b0;
      errReg  <= 1'b0;
    end else if (strobe.load) begin
      curLine <= firstLineIn;
      endLine <= lastLineIn;
      opReg   <= cmdOp;
      allReg  <= cmdAll;
      errReg  <= cmdBad;
    end else if (strobe.step) begin
      curLine <= curLine + 1'b1;
    end
  end

  assign lastHit = (curLine == endLine);
  assign errFlag = errReg;
  assign reqOp   = opReg;
  assign reqAll  = allReg;

  // Index sits in the low bits; a line address keeps its offset bits clear.
  assign reqAddr = allReg ? ADDR_W'(curLine) : {curLine, {OFF_W{1'b0}}};

endmodule

// File: rtl/cms_control.sv
module cms_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic                cmdBad,
  input  logic                lastHit,
  input  logic                errFlag,
  input  logic                reqReady,
  output logic                cmdReady,
  output logic                reqValid,
  output logic                busy,
  output logic                done,
  output logic                error,
  output cms_pkg::seqStrobe_t strobe
);
  import cms_pkg::*;

  seqState_e state;
  seqState_e stateNext;
  logic      accept;
  logic      handshake;

  assign accept    = cmdValid && (state == ST_IDLE);
  assign handshake = (state == ST_ISSUE) && reqReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = cmdBad ? ST_FIN : ST_ISSUE;
      ST_ISSUE: if (handshake && lastHit) stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load = accept;
    strobe.step = handshake && !lastHit;
  end

  assign cmdReady = (state == ST_IDLE);
  assign reqValid = (state == ST_ISSUE);
  assign busy     = (state == ST_ISSUE);
  assign done     = (state == ST_FIN);
  assign error    = (state == ST_FIN) && errFlag;

endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SETS   = 64,
  parameter int NUM_WAYS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic              cmdAll,
  input  logic [ADDR_W-1:0] cmdStart,
  input  logic [ADDR_W-1:0] cmdLen,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [1:0]        reqOp,
  output logic              reqAll,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              done,
  output logic              error
);
  import cms_pkg::*;

  seqStrobe_t strobe;
  logic       cmdBad;
  logic       lastHit;
  logic       errFlag;

  cms_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdBad  (cmdBad),
    .lastHit (lastHit),
    .errFlag (errFlag),
    .reqReady(reqReady),
    .cmdReady(cmdReady),
    .reqValid(reqValid),
    .busy    (busy),
    .done    (done),
    .error   (error),
    .strobe  (strobe)
  );

  cms_datapath #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_SETS  (NUM_SETS),
    .NUM_WAYS  (NUM_WAYS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdOp   (cmdOp),
    .cmdAll  (cmdAll),
    .cmdStart(cmdStart),
    .cmdLen  (cmdLen),
    .cmdBad  (cmdBad),
    .lastHit (lastHit),
    .errFlag (errFlag),
    .reqOp   (reqOp),
    .reqAll  (reqAll),
    .reqAddr (reqAddr)
  );

endmodule

// File: rtl/cache_maint_seq_chk.sv
module cache_maint_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqOp,
  input logic              reqAll,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              busy,
  input logic              done,
  input logic              error
);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqOp) && $stable(reqAll)));

  a_r4_addr_moves: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqValid || (reqAddr != $past(reqAddr))));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  a_r10_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!busy && !reqValid && !done));

  a_r6_err_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> !$past(reqValid));

endmodule

bind cache_maint_seq cache_maint_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdReady(cmdReady),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqOp   (reqOp),
  .reqAll  (reqAll),
  .reqAddr (reqAddr),
  .busy    (busy),
  .done    (done),
  .error   (error)
);

// File: tb/cache_maint_seq_tb.sv
module cache_maint_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int OFF_W      = 6;
  localparam int TOTAL      = 64 * 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [1:0]        cmdOp = '0;
  logic              cmdAll = 1'b0;
  logic [ADDR_W-1:0] cmdStart = '0;
  logic [ADDR_W-1:0] cmdLen = '0;
  logic              reqValid;
  logic              reqReady = 1'b0;
  logic [1:0]        reqOp;
  logic              reqAll;
  logic [ADDR_W-1:0] reqAddr;
  logic              busy;
  logic              done;
  logic              error;

  int nRun  = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_maint_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAll(cmdAll), .cmdStart(cmdStart), .cmdLen(cmdLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqAll(reqAll),
    .reqAddr(reqAddr), .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] lastByteOf(input logic [31:0] st, input logic [31:0] ln);
    if (ln == 0) return {1'b0, st};
    return {1'b0, st} + {1'b0, ln} - 33'd1;
  endfunction

  task automatic runCmd(input logic [1:0] op, input bit all, input logic [31:0] st,
                        input logic [31:0] ln, input bit stallCmd);
    logic [32:0] lb;
    logic [25:0] first;
    logic [25:0] last;
    logic [25:0] cur;
    logic [31:0] expAddr;
    bit          expErr;
    int          expCnt;
    int          got = 0;
    int          cyc = 0;
    bit          fin = 0;
    lb = lastByteOf(st, ln);
    if (all) begin first = '0; last = 26'(TOTAL - 1); end
    else begin first = st[31:OFF_W]; last = lb[31:OFF_W]; end
    expErr = (op == 2'd3) || (!all && lb[32]);
    expCnt = expErr ? 0 : int'(last - first) + 1;
    cur = first;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAll = all; cmdStart = st; cmdLen = ln;
    @(negedge clk);
    if (stallCmd) begin
      cmdOp = 2'd1; cmdAll = ~all; cmdStart = $urandom; cmdLen = $urandom;
    end else begin
      cmdValid = 1'b0;
    end
    while (!fin && cyc < 5000) begin
      if (done) begin
        fin = 1;
        cmdValid = 1'b0;
        reqReady = 1'b0;
        chk(error == expErr, "R6 R1 error flag", 64'(error), 64'(expErr));
        chk(got == expCnt, "R3 R5 R7 request count", 64'(got), 64'(expCnt));
        chk(!busy, "R10 busy low at done", 64'(busy), 64'd0);
      end else if (reqValid) begin
        expAddr = all ? 32'(cur) : {cur, {OFF_W{1'b0}}};
        chk(reqAddr == expAddr, all ? "R7 index" : (got == 0 ? "R2 first line" : "R4 next line"),
            64'(reqAddr), 64'(expAddr));
        chk(reqOp == op && reqAll == all, "R1 R7 op/mode", {61'd0, reqAll, reqOp}, {61'd0, all, op});
        chk(busy && !cmdReady, "R9 R10 busy, command port closed", {62'd0, busy, cmdReady}, 64'd2);
        reqReady = ($urandom % 3) != 0;
        if (reqReady) begin cur = cur + 1'b1; got++; end
      end else begin
        reqReady = 1'b0;
      end
      cyc++;
      if (!fin) @(negedge clk);
    end
    if (!fin) chk(1'b0, "R10 command never completed", 64'(cyc), 64'd5000);
    @(negedge clk);
    chk(!done && cmdReady && !error, "R10 done single pulse, idle again",
        {61'd0, done, cmdReady, error}, 64'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nRun, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cmdReady && !busy && !done && !error && !reqValid, "R11 reset state",
        {59'd0, cmdReady, busy, done, error, reqValid}, 64'h10);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady && !busy && !done && !reqValid, "R11 idle after reset",
        {60'd0, cmdReady, busy, done, reqValid}, 64'h8);

    runCmd(2'd0, 0, 32'h0000_003F, 32'd2, 0);          // R2 R3 crosses one boundary
    runCmd(2'd1, 0, 32'h0000_1234, 32'd0, 0);          // R5 zero length
    runCmd(2'd2, 0, 32'h0000_2000, 32'd64, 0);         // R3 aligned single line
    runCmd(2'd2, 0, 32'h0000_2001, 32'd64, 1);         // R9 command offered while busy
    runCmd(2'd0, 0, 32'hFFFF_FFF0, 32'h20, 0);         // R6 wraps
    runCmd(2'd1, 0, 32'hFFFF_FFC0, 32'h40, 0);         // R6 ends on top byte, legal
    runCmd(2'd3, 0, 32'h0000_1000, 32'd8, 0);          // R1 reserved code
    runCmd(2'd2, 1, 32'hDEAD_BEEF, 32'h1234, 1);       // R7 whole cache, fields ignored
    runCmd(2'd3, 1, 32'h0, 32'h0, 0);                  // R1 reserved in whole mode

    for (int i = 0; i < 40; i++) begin
      logic [31:0] st;
      logic [31:0] ln;
      st = $urandom;
      if (i % 4 == 0) st = 32'hFFFF_FE00 | ($urandom & 32'h1FF);
      ln = $urandom % 700;
      runCmd(2'($urandom % 3), 0, st, ln, (i % 5) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule